// File: doc/BRIEF.md
# Precise Exception Commit Controller

This block makes traps precise in a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). Each fetched instruction gets a small tag holding its valid bit, its PC, a pending-exception flag and a cause code. The tag moves down the pipe in step with the instruction. A stage that detects a fault records it in the tag, unless an earlier stage has already recorded one. Nothing is acted on until the instruction reaches the memory stage, which is the commit point.

At the commit point the controller resolves three things in a fixed priority order: an external interrupt, then the synchronous fault carried in the tag or raised by the memory stage, then a return-from-exception instruction. When a trap is taken, the controller:
- records the cause and the faulting PC,
- squashes the younger instructions,
- blocks writeback of the committing instruction,
- steers fetch to a fixed handler address,
- enters privileged mode with interrupts masked.

A return-from-exception does the reverse. It unmasks interrupts, leaves privileged mode and steers fetch back to the saved PC. The pipeline advances every cycle. The datapath and register file sit outside the block.

Top module: `exc_commit_ctrl`

## Requirements
- R1: After synchronous reset, the saved cause is 0, the saved PC is 0, the block is in privileged mode with interrupts masked, and no kill, redirect or trap output is active.
- R2: A fault raised for an instruction in fetch, decode or execute is held until that instruction reaches the memory stage. The trap for a fetch-stage fault therefore appears exactly three cycles after the instruction was fetched, and never earlier.
- R3: When one instruction faults in several stages, the fault from the earliest stage is the one recorded.
- R4: The saved cause codes are:
  - 0: external interrupt
  - 1: fetch address fault
  - 2: illegal opcode in decode
  - 3: overflow in execute
  - 4: data address fault in memory
- R5: An external interrupt is taken only when interrupts are enabled and a valid instruction occupies the memory stage. When it is taken, it wins over any synchronous fault of that instruction and records cause 0.
- R6: In the cycle a trap is taken, fetch, decode and execute are killed, writeback is suppressed, and fetch is redirected to HANDLER_PC. On the next cycle the saved PC holds the committing instruction's PC, the block is in privileged mode, and interrupts are masked.
- R7: A valid return-from-exception at commit with no trap does the following: it kills fetch, decode and execute, redirects fetch to the saved PC, and leaves writeback enabled. On the next cycle interrupts are enabled and the block is in user mode. A trap on the same instruction takes precedence over the return.
- R8: Killed stages become bubbles with cleared fault flags. Faults signalled against bubbles are ignored, so in the three cycles after a kill no trap and no commit can occur.
- R9: commit_valid is high exactly when a valid instruction is in the memory stage and no trap is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| if_valid | input | 1 | Fetch holds a real instruction |
| if_pc | input | 32 | PC of the fetched instruction |
| if_addr_fault | input | 1 | Fetch address fault |
| id_illegal | input | 1 | Decode found an illegal opcode |
| ex_overflow | input | 1 | Execute overflowed |
| mem_addr_fault | input | 1 | Data address fault in memory stage |
| mem_is_rfe | input | 1 | Memory-stage instruction is return-from-exception |
| irq | input | 1 | External interrupt request |
| kill_f | output | 1 | Squash fetch |
| kill_d | output | 1 | Squash decode |
| kill_e | output | 1 | Squash execute |
| wb_suppress | output | 1 | Block writeback of committing instruction |
| commit_valid | output | 1 | Memory-stage instruction commits |
| trap_taken | output | 1 | Trap taken this cycle |
| redirect_valid | output | 1 | Fetch must restart at redirect_pc |
| redirect_pc | output | 32 | Handler PC or saved PC |
| cause_q | output | 3 | Saved cause code |
| epc_q | output | 32 | Saved exception PC |
| int_enable | output | 1 | Interrupts enabled |
| kernel_mode | output | 1 | Privileged mode |

## Verification
The hardest state to reach is an instruction that carries faults from several stages and also meets an enabled interrupt at commit. Getting there needs a return-from-exception to have committed earlier, and that return must not be squashed by a trap ahead of it. The stimulus first steers one instruction through fetch, decode and execute faults together. It then commits a return to unmask interrupts, and then raises an interrupt against a faulting instruction. A long random run follows, with sparse faults, returns and interrupts, and every output is compared each cycle with a cycle-accurate model in the bench.

// File: rtl/exc_pkg.sv
package exc_pkg;

    parameter int PC_W = 32;
    localparam int CAUSE_W = 3;
    // carried stages: decode, execute, memory
    localparam int NSTAGE = 3;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_IRQ     = 3'd0,
        CAUSE_FETCH   = 3'd1,
        CAUSE_ILLEGAL = 3'd2,
        CAUSE_OVF     = 3'd3,
        CAUSE_DADDR   = 3'd4
    } cause_e;

    typedef struct packed {
        logic            valid;
        logic            exc;
        cause_e          cause;
        logic [PC_W-1:0] pc;
    } slot_t;

    // Cause code raised by the stage feeding carried stage idx
    function automatic cause_e feed_code(int idx);
        case (idx)
            0:       return CAUSE_FETCH;
            1:       return CAUSE_ILLEGAL;
            default: return CAUSE_OVF;
        endcase
    endfunction

    // Record a fault unless an older one exists; bubbles never carry faults
    function automatic slot_t add_fault(slot_t s, logic fault, cause_e code);
        slot_t r;
        r = s;
        if (!s.valid) begin
            r.exc   = 1'b0;
            r.cause = CAUSE_IRQ;
        end else if (!s.exc && fault) begin
            r.exc   = 1'b1;
            r.cause = code;
        end
        return r;
    endfunction

endpackage

// File: rtl/exc_stage_reg.sv
module exc_stage_reg
    import exc_pkg::*;
#(
    parameter cause_e CODE = CAUSE_FETCH
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  flush,
    input  slot_t slot_in,
    input  logic  fault_in,
    output slot_t slot_q
);

    slot_t merged;

    always_comb merged = add_fault(slot_in, fault_in, CODE);

    always_ff @(posedge clk) begin
        if (rst || flush) slot_q <= '0;
        else              slot_q <= merged;
    end

    p_flush_bubble_r8: assert property (@(posedge clk) disable iff (rst)
        flush |=> (!slot_q.valid && !slot_q.exc));

    p_bubble_clean_r8: assert property (@(posedge clk) disable iff (rst)
        !slot_q.valid |-> !slot_q.exc);

endmodule

// File: rtl/exc_commit_unit.sv
module exc_commit_unit
    import exc_pkg::*;
#(
    parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_0080
) (
    input  logic            clk,
    input  logic            rst,
    input  slot_t           m_slot,
    input  logic            mem_addr_fault,
    input  logic            mem_is_rfe,
    input  logic            irq,
    input  logic            ie,
    input  logic [PC_W-1:0] epc,
    output logic            trap,
    output logic            rfe,
    output cause_e          cause_sel,
    output logic            commit_valid,
    output logic            redirect_valid,
    output logic [PC_W-1:0] redirect_pc
);

    slot_t m_full;
    logic  irq_take;
    logic  sync_take;

    always_comb begin
        m_full    = add_fault(m_slot, mem_addr_fault, CAUSE_DADDR);
        irq_take  = irq && ie && m_slot.valid;
        sync_take = m_full.valid && m_full.exc;
        trap      = irq_take || sync_take;
        rfe       = m_slot.valid && mem_is_rfe && !trap;
        cause_sel = irq_take ? CAUSE_IRQ : m_full.cause;
        commit_valid   = m_slot.valid && !trap;
        redirect_valid = trap || rfe;
        redirect_pc    = trap ? HANDLER_PC : (rfe ? epc : '0);
    end

    p_irq_first_r5: assert property (@(posedge clk) disable iff (rst)
        (irq && ie && m_slot.valid) |-> (trap && cause_sel == CAUSE_IRQ));

    p_bubble_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !m_slot.valid |-> (!trap && !rfe && !commit_valid));

endmodule

// File: rtl/exc_status_regs.sv
module exc_status_regs
    import exc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            trap,
    input  logic            rfe,
    input  cause_e          cause_in,
    input  logic [PC_W-1:0] pc_in,
    output cause_e          cause_q,
    output logic [PC_W-1:0] epc_q,
    output logic            ie_q,
    output logic            kmode_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q <= CAUSE_IRQ;
            epc_q   <= '0;
            ie_q    <= 1'b0;
            kmode_q <= 1'b1;
        end else if (trap) begin
            cause_q <= cause_in;
            epc_q   <= pc_in;
            ie_q    <= 1'b0;
            kmode_q <= 1'b1;
        end else if (rfe) begin
            ie_q    <= 1'b1;
            kmode_q <= 1'b0;
        end
    end

    p_trap_mode_r6: assert property (@(posedge clk) disable iff (rst)
        trap |=> (kmode_q && !ie_q && epc_q == $past(pc_in)));

    p_rfe_mode_r7: assert property (@(posedge clk) disable iff (rst)
        rfe |=> (!kmode_q && ie_q && $stable(epc_q)));

endmodule

// File: rtl/exc_commit_ctrl.sv
module exc_commit_ctrl
    import exc_pkg::*;
#(
    parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_0080
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            if_valid,
    input  logic [PC_W-1:0] if_pc,
    input  logic            if_addr_fault,
    input  logic            id_illegal,
    input  logic            ex_overflow,
    input  logic            mem_addr_fault,
    input  logic            mem_is_rfe,
    input  logic            irq,
    output logic            kill_f,
    output logic            kill_d,
    output logic            kill_e,
    output logic            wb_suppress,
    output logic            commit_valid,
    output logic            trap_taken,
    output logic            redirect_valid,
    output logic [PC_W-1:0] redirect_pc,
    output logic [2:0]      cause_q,
    output logic [PC_W-1:0] epc_q,
    output logic            int_enable,
    output logic            kernel_mode
);

    slot_t              fetch_slot;
    slot_t              stg_in [NSTAGE];
    slot_t              stg_q  [NSTAGE];
    logic [NSTAGE-1:0]  stg_fault;
    logic               flush;
    logic               trap;
    logic               rfe;
    cause_e             cause_sel;
    cause_e             cause_r;

    always_comb begin
        fetch_slot       = '0;
        fetch_slot.valid = if_valid;
        fetch_slot.pc    = if_pc;
    end

    assign stg_fault = {ex_overflow, id_illegal, if_addr_fault};
    assign flush     = trap || rfe;

    for (genvar i = 0; i < NSTAGE; i++) begin : g_stage
        if (i == 0) begin : g_head
            assign stg_in[i] = fetch_slot;
        end else begin : g_link
            assign stg_in[i] = stg_q[i-1];
        end
        exc_stage_reg #(.CODE(feed_code(i))) u_stage (
            .clk      (clk),
            .rst      (rst),
            .flush    (flush),
            .slot_in  (stg_in[i]),
            .fault_in (stg_fault[i]),
            .slot_q   (stg_q[i])
        );
    end

    exc_commit_unit #(.HANDLER_PC(HANDLER_PC)) u_commit (
        .clk            (clk),
        .rst            (rst),
        .m_slot         (stg_q[NSTAGE-1]),
        .mem_addr_fault (mem_addr_fault),
        .mem_is_rfe     (mem_is_rfe),
        .irq            (irq),
        .ie             (int_enable),
        .epc            (epc_q),
        .trap           (trap),
        .rfe            (rfe),
        .cause_sel      (cause_sel),
        .commit_valid   (commit_valid),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc)
    );

    exc_status_regs u_status (
        .clk      (clk),
        .rst      (rst),
        .trap     (trap),
        .rfe      (rfe),
        .cause_in (cause_sel),
        .pc_in    (stg_q[NSTAGE-1].pc),
        .cause_q  (cause_r),
        .epc_q    (epc_q),
        .ie_q     (int_enable),
        .kmode_q  (kernel_mode)
    );

    assign cause_q     = cause_r;
    assign trap_taken  = trap;
    assign kill_f      = flush;
    assign kill_d      = flush;
    assign kill_e      = flush;
    assign wb_suppress = trap;

    p_one_redirect_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({trap, rfe}));

    p_trap_kills_r6: assert property (@(posedge clk) disable iff (rst)
        trap_taken |-> (kill_f && kill_d && kill_e && wb_suppress && redirect_pc == HANDLER_PC));

    p_after_kill_r8: assert property (@(posedge clk) disable iff (rst)
        flush |=> !trap_taken);

endmodule

// File: tb/sim_exc_commit_ctrl.sv
module sim_exc_commit_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] HANDLER = 32'h0000_0080;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic if_valid = 0, if_addr_fault = 0, id_illegal = 0, ex_overflow = 0;
    logic mem_addr_fault = 0, mem_is_rfe = 0, irq = 0;
    logic [31:0] if_pc = '0;
    logic kill_f, kill_d, kill_e, wb_suppress, commit_valid, trap_taken, redirect_valid;
    logic [31:0] redirect_pc, epc_q;
    logic [2:0] cause_q;
    logic int_enable, kernel_mode;

    int n_chk = 0;
    int n_fail = 0;
    logic last_trap;

    // bench model: carried stages 0=decode 1=execute 2=memory
    logic        mv [3];
    logic        mx [3];
    logic [2:0]  mc [3];
    logic [31:0] mp [3];
    logic        e_ie, e_km;
    logic [2:0]  e_cause;
    logic [31:0] e_epc;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_commit_ctrl #(.HANDLER_PC(HANDLER)) u0 (
        .clk(clk), .rst(rst), .if_valid(if_valid), .if_pc(if_pc),
        .if_addr_fault(if_addr_fault), .id_illegal(id_illegal),
        .ex_overflow(ex_overflow), .mem_addr_fault(mem_addr_fault),
        .mem_is_rfe(mem_is_rfe), .irq(irq), .kill_f(kill_f), .kill_d(kill_d),
        .kill_e(kill_e), .wb_suppress(wb_suppress), .commit_valid(commit_valid),
        .trap_taken(trap_taken), .redirect_valid(redirect_valid),
        .redirect_pc(redirect_pc), .cause_q(cause_q), .epc_q(epc_q),
        .int_enable(int_enable), .kernel_mode(kernel_mode)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 3; i++) begin
            mv[i] = 0; mx[i] = 0; mc[i] = 0; mp[i] = '0;
        end
        e_ie = 0; e_km = 1; e_cause = 0; e_epc = '0;
    endtask

    // One cycle: drive at negedge, check outputs, advance model at posedge
    task automatic step(logic v, logic [31:0] pc, logic faf, logic ill,
                        logic ovf, logic maf, logic rf, logic rq);
        logic mfx, irq_t, trp, rt, fl;
        logic [2:0] mcs, ec;
        @(negedge clk);
        if_valid = v; if_pc = pc; if_addr_fault = faf; id_illegal = ill;
        ex_overflow = ovf; mem_addr_fault = maf; mem_is_rfe = rf; irq = rq;
        #1;
        mfx   = mv[2] && (mx[2] || maf);
        mcs   = mx[2] ? mc[2] : 3'd4;
        irq_t = rq && e_ie && mv[2];
        trp   = irq_t || mfx;
        ec    = irq_t ? 3'd0 : mcs;
        rt    = mv[2] && rf && !trp;
        fl    = trp || rt;
        chk("R2 trap_taken", {31'b0, trap_taken}, {31'b0, trp});
        chk("R6 kill_f", {31'b0, kill_f}, {31'b0, fl});
        chk("R6 kill_d", {31'b0, kill_d}, {31'b0, fl});
        chk("R6 kill_e", {31'b0, kill_e}, {31'b0, fl});
        chk("R6 wb_suppress", {31'b0, wb_suppress}, {31'b0, trp});
        chk("R9 commit_valid", {31'b0, commit_valid}, {31'b0, mv[2] && !trp});
        chk("R7 redirect_valid", {31'b0, redirect_valid}, {31'b0, fl});
        if (fl) chk(trp ? "R6 redirect_pc" : "R7 redirect_pc", redirect_pc, trp ? HANDLER : e_epc);
        chk("R4 cause_q", {29'b0, cause_q}, {29'b0, e_cause});
        chk("R6 epc_q", epc_q, e_epc);
        chk("R7 int_enable", {31'b0, int_enable}, {31'b0, e_ie});
        chk("R7 kernel_mode", {31'b0, kernel_mode}, {31'b0, e_km});
        last_trap = trap_taken;
        @(posedge clk);
        if (trp) begin
            e_cause = ec; e_epc = mp[2]; e_ie = 0; e_km = 1;
        end else if (rt) begin
            e_ie = 1; e_km = 0;
        end
        if (fl) begin
            for (int i = 0; i < 3; i++) begin mv[i] = 0; mx[i] = 0; mc[i] = 0; end
        end else begin
            mv[2] = mv[1]; mp[2] = mp[1];
            mx[2] = mv[1] && (mx[1] || ovf); mc[2] = !mv[1] ? 3'd0 : (mx[1] ? mc[1] : (ovf ? 3'd3 : 3'd0));
            mv[1] = mv[0]; mp[1] = mp[0];
            mx[1] = mv[0] && (mx[0] || ill); mc[1] = !mv[0] ? 3'd0 : (mx[0] ? mc[0] : (ill ? 3'd2 : 3'd0));
            mv[0] = v; mp[0] = pc; mx[0] = v && faf; mc[0] = (v && faf) ? 3'd1 : 3'd0;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int seed;
        logic [31:0] pcc;
        seed = 32'h1d5e;
        void'($urandom(seed));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        // R1 reset state
        #1;
        chk("R1 cause", {29'b0, cause_q}, 32'd0);
        chk("R1 epc", epc_q, 32'd0);
        chk("R1 kernel", {31'b0, kernel_mode}, 32'd1);
        chk("R1 ie", {31'b0, int_enable}, 32'd0);
        chk("R1 redirect", {31'b0, redirect_valid}, 32'd0);

        // R3: same instruction faults in fetch, decode, execute, memory
        step(1, 32'h100, 1, 0, 0, 0, 0, 0);
        step(0, 32'h0,   0, 1, 0, 0, 0, 0);
        step(0, 32'h0,   0, 0, 1, 0, 0, 0);
        chk("R2 no early trap", {31'b0, last_trap}, 32'd0);
        step(0, 32'h0,   0, 0, 0, 1, 0, 0);
        chk("R2 trap at commit", {31'b0, last_trap}, 32'd1);
        #1;
        chk("R3 earliest cause", {29'b0, cause_q}, 32'd1);
        chk("R6 epc", epc_q, 32'h100);

        // R5: interrupt masked, then return-from-exception to epc
        step(1, 32'h200, 0, 0, 0, 0, 0, 1);
        step(1, 32'h204, 0, 0, 0, 0, 0, 1);
        step(1, 32'h208, 0, 0, 0, 0, 0, 1);
        step(0, 32'h0,   0, 0, 0, 0, 1, 1);
        chk("R5 masked irq", {31'b0, last_trap}, 32'd0);
        #1;
        chk("R7 user mode", {31'b0, kernel_mode}, 32'd0);
        chk("R7 ie on", {31'b0, int_enable}, 32'd1);

        // R5: interrupt beats an overflow on the same instruction
        step(1, 32'h300, 0, 0, 0, 0, 0, 0);
        step(0, 32'h0,   0, 0, 0, 0, 0, 0);
        step(0, 32'h0,   0, 0, 1, 0, 0, 0);
        step(0, 32'h0,   0, 0, 0, 1, 1, 1);
        #1;
        chk("R5 irq cause", {29'b0, cause_q}, 32'd0);
        chk("R5 irq epc", epc_q, 32'h300);

        // R8: faults against killed bubbles are ignored
        step(1, 32'h400, 1, 0, 0, 0, 0, 0);
        step(1, 32'h404, 0, 0, 0, 0, 0, 0);
        step(1, 32'h408, 0, 0, 0, 0, 0, 0);
        step(1, 32'h40c, 0, 0, 0, 0, 0, 0);
        for (int k = 0; k < 3; k++) begin
            step(0, 32'h0, 1, 1, 1, 1, 0, 0);
            chk("R8 bubble no trap", {31'b0, last_trap}, 32'd0);
        end

        // random run
        pcc = 32'h1000;
        for (int n = 0; n < 4000; n++) begin
            step(($urandom % 8) != 0, pcc,
                 ($urandom % 10) == 0, ($urandom % 10) == 0,
                 ($urandom % 10) == 0, ($urandom % 12) == 0,
                 ($urandom % 6) == 0,  ($urandom % 9) == 0);
            pcc = pcc + 32'd4;
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule